// File: doc/BRIEF.md
# Debug Port Register Front End

This block is the register front end on the target side of a debug port. Each access comes from the serial link layer as one cycle. It carries a port/access selector, a read/write flag, two word-address bits and a 32-bit write word. The block decides whether the access goes to a register held locally or to one of several access ports behind it.

Local registers are reached directly by the two address bits. They are an identification word, a banked control/status slot, a selection register and a read buffer. Access-port traffic uses the selection register to build a full address. It names the target port and a bank of four words. The two wire bits then pick one word inside that bank. The resulting request goes out on a single-outstanding request/response interface. When the port answers, the block returns the result to the link layer with a status code.

Top module: `dpreg_front`

## Requirements
- R1: After reset, resp_valid and ap_req_valid are low, and the selection, control/status and read buffer registers read as zero.
- R2: A local access (acc_ap=0) accepted while no port access is outstanding is answered exactly one cycle later with status OK (2'b00). A read at address bits 2'b00 returns the parameter DP_ID, and writes there have no effect.
- R3: Address bits 2'b10 reach the selection register. It keeps port number in bits [31:24], port bank in bits [7:4] and local bank in bits [3:0]. All other bits read zero.
- R4: Address bits 2'b01 reach a 32-bit read/write control/status register when the local bank is 0. With any other local bank it reads zero and writes are ignored.
- R5: A port access to an implemented port (port number < NUM_AP) raises ap_req_valid for exactly one cycle, on the cycle after acceptance. It carries ap_req_sel = port number, ap_req_off = {port bank, address bits, 2'b00}, ap_req_wr = !acc_rd and the write word.
- R6: The answer to an implemented port access is given one cycle after ap_rsp_valid, with status OK. A read returns ap_rsp_rdata.
- R7: A port access with port number >= NUM_AP issues no request. It is answered one cycle later with status OK and data zero.
- R8: Address bits 2'b11 read the buffer holding the data of the last port read, which is zero after a read of an unimplemented port. Writes there and local reads leave it unchanged.
- R9: An access presented while a port access is outstanding has no effect. It is answered one cycle later with status BUSY (2'b01). If the port answer arrives in that same cycle, the port answer is returned and the new access is discarded.
- R10: Every response to a write, and every BUSY response, carries data zero. resp_rdata is zero in cycles without a response.
- R11: ap_rsp_valid is ignored while no port access is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access presented this cycle |
| acc_ap | input | 1 | 1 = access port, 0 = local register |
| acc_rd | input | 1 | 1 = read, 0 = write |
| acc_addr | input | 2 | Word address bits from the wire |
| acc_wdata | input | 32 | Write word |
| resp_valid | output | 1 | Response present this cycle |
| resp_rdata | output | 32 | Read data of the response |
| resp_status | output | 2 | 2'b00 OK, 2'b01 BUSY |
| ap_req_valid | output | 1 | One-cycle request to an access port |
| ap_req_sel | output | AP_IDX_W | Target port index |
| ap_req_off | output | 8 | Byte offset of the port register |
| ap_req_wr | output | 1 | Request is a write |
| ap_req_wdata | output | 32 | Request write word |
| ap_rsp_valid | input | 1 | Port has completed the request |
| ap_rsp_rdata | input | 32 | Port read data |

## Verification
A corrupted selection register shows up as a wrong offset or index on the next port request. It also shows up as wrong data one cycle after a read of address 2'b10. A stuck outstanding flag turns every later access into a BUSY answer. A flag that clears too early loses the port answer, so the host is never answered. Each of these shows at the ports within one or two cycles of the next access. The bench runs a behavioural model that is compared on every clock, so the first wrong cycle is reported.

// File: rtl/dpreg_pkg.sv
`timescale 1ns/1ps
// Shared types for the debug port register front end.
// Assumes 32-bit registers with word-aligned addresses.
package dpreg_pkg;
    typedef enum logic [1:0] {
        ST_OK   = 2'b00,
        ST_BUSY = 2'b01
    } dp_status_e;

    localparam logic [1:0] A_IDENT  = 2'b00;
    localparam logic [1:0] A_BANKED = 2'b01;
    localparam logic [1:0] A_SELECT = 2'b10;
    localparam logic [1:0] A_RDBUF  = 2'b11;

    typedef struct packed {
        logic [7:0] port;
        logic [3:0] pbank;
        logic [3:0] lbank;
    } select_t;

    // Word image of the selection register as seen on a read.
    function automatic logic [31:0] select_word(select_t s);
        return {s.port, 16'h0000, s.pbank, s.lbank};
    endfunction
endpackage

// File: rtl/dpreg_select.sv
`timescale 1ns/1ps
// Holds the selection register and the bank-0 control/status word.
// Assumes the caller has already decoded the write strobes.
module dpreg_select
    import dpreg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_sel,
    input  select_t     sel_wdata,
    input  logic        wr_ctrl,
    input  logic [31:0] ctrl_wdata,
    output select_t     sel_q,
    output logic [31:0] ctrl_q
);
    // Update the selection register on a decoded write.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= '0;
        else if (wr_sel) sel_q <= sel_wdata;
    end

    // Update the control/status word on a decoded write.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= ctrl_wdata;
    end
endmodule

// File: rtl/dpreg_local_rd.sv
`timescale 1ns/1ps
// Read multiplexer for the locally held registers.
// Purely combinational; the address bits pick the word and the
// local bank gates the banked slot.
module dpreg_local_rd
    import dpreg_pkg::*;
#(
    parameter logic [31:0] DP_ID = 32'h0C0D_E001
)(
    input  logic [1:0]  addr,
    input  select_t     sel,
    input  logic [31:0] ctrl,
    input  logic [31:0] rdbuf,
    output logic [31:0] rdata
);
    // Select the read word for a local access.
    always_comb begin
        unique case (addr)
            A_IDENT:  rdata = DP_ID;
            A_BANKED: rdata = (sel.lbank == 4'h0) ? ctrl : 32'h0;
            A_SELECT: rdata = select_word(sel);
            default:  rdata = rdbuf;
        endcase
    end
endmodule

// File: rtl/dpreg_ap_ctrl.sv
`timescale 1ns/1ps
// Issues one request toward an access port and tracks it until the
// port answers. Assumes launch is never raised while pend is high.
module dpreg_ap_ctrl #(
    parameter int AP_IDX_W = 1
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                launch,
    input  logic                launch_rd,
    input  logic [AP_IDX_W-1:0] launch_sel,
    input  logic [7:0]          launch_off,
    input  logic [31:0]         launch_wdata,
    input  logic                rsp_valid,
    output logic                req_valid,
    output logic [AP_IDX_W-1:0] req_sel,
    output logic [7:0]          req_off,
    output logic                req_wr,
    output logic [31:0]         req_wdata,
    output logic                pend,
    output logic                done,
    output logic                done_rd
);
    logic rd_q;

    // A port answer only counts while a request is outstanding.
    assign done    = rsp_valid && pend;
    assign done_rd = rd_q;

    // One-cycle request strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) req_valid <= 1'b0;
        else        req_valid <= launch;
    end

    // Capture request fields when a request is launched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_sel   <= '0;
            req_off   <= '0;
            req_wr    <= 1'b0;
            req_wdata <= '0;
            rd_q      <= 1'b0;
        end else if (launch) begin
            req_sel   <= launch_sel;
            req_off   <= launch_off;
            req_wr    <= !launch_rd;
            req_wdata <= launch_wdata;
            rd_q      <= launch_rd;
        end
    end

    // Outstanding flag: set on launch, cleared on the answer.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend <= 1'b0;
        else if (launch) pend <= 1'b1;
        else if (done)   pend <= 1'b0;
    end
endmodule

// File: rtl/dpreg_front.sv
`timescale 1ns/1ps
// Debug port register front end: decodes each access into a local
// register or an access-port request and returns data and status.
// Assumes at most one access per cycle and one port request in flight.
module dpreg_front
    import dpreg_pkg::*;
#(
    parameter int          NUM_AP   = 2,
    parameter logic [31:0] DP_ID    = 32'h0C0D_E001,
    parameter int          AP_IDX_W = (NUM_AP > 1) ? $clog2(NUM_AP) : 1
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_valid,
    input  logic                acc_ap,
    input  logic                acc_rd,
    input  logic [1:0]          acc_addr,
    input  logic [31:0]         acc_wdata,
    output logic                resp_valid,
    output logic [31:0]         resp_rdata,
    output logic [1:0]          resp_status,
    output logic                ap_req_valid,
    output logic [AP_IDX_W-1:0] ap_req_sel,
    output logic [7:0]          ap_req_off,
    output logic                ap_req_wr,
    output logic [31:0]         ap_req_wdata,
    input  logic                ap_rsp_valid,
    input  logic [31:0]         ap_rsp_rdata
);
    select_t     sel;
    logic [31:0] ctrl;
    logic [31:0] rdbuf;
    logic [31:0] local_rdata;
    logic        ap_pend;
    logic        ap_done;
    logic        ap_done_rd;
    logic        take, dp_wr, ap_hit, launch, miss;
    select_t     sel_wdata;

    // Decode of the incoming access.
    assign take      = acc_valid && !ap_pend;
    assign dp_wr     = take && !acc_ap && !acc_rd;
    assign ap_hit    = 32'(sel.port) < NUM_AP;
    assign launch    = take && acc_ap && ap_hit;
    assign miss      = take && acc_ap && !ap_hit;
    assign sel_wdata = '{port: acc_wdata[31:24], pbank: acc_wdata[7:4], lbank: acc_wdata[3:0]};

    dpreg_select u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_sel     (dp_wr && acc_addr == A_SELECT),
        .sel_wdata  (sel_wdata),
        .wr_ctrl    (dp_wr && acc_addr == A_BANKED && sel.lbank == 4'h0),
        .ctrl_wdata (acc_wdata),
        .sel_q      (sel),
        .ctrl_q     (ctrl)
    );

    dpreg_local_rd #(.DP_ID(DP_ID)) u_rd (
        .addr  (acc_addr),
        .sel   (sel),
        .ctrl  (ctrl),
        .rdbuf (rdbuf),
        .rdata (local_rdata)
    );

    dpreg_ap_ctrl #(.AP_IDX_W(AP_IDX_W)) u_ap (
        .clk          (clk),
        .rst_n        (rst_n),
        .launch       (launch),
        .launch_rd    (acc_rd),
        .launch_sel   (sel.port[AP_IDX_W-1:0]),
        .launch_off   ({sel.pbank, acc_addr, 2'b00}),
        .launch_wdata (acc_wdata),
        .rsp_valid    (ap_rsp_valid),
        .req_valid    (ap_req_valid),
        .req_sel      (ap_req_sel),
        .req_off      (ap_req_off),
        .req_wr       (ap_req_wr),
        .req_wdata    (ap_req_wdata),
        .pend         (ap_pend),
        .done         (ap_done),
        .done_rd      (ap_done_rd)
    );

    // Read buffer: last port read result, zero for an absent port.
    always_ff @(posedge clk) begin
        if (!rst_n)                   rdbuf <= '0;
        else if (ap_done && ap_done_rd) rdbuf <= ap_rsp_rdata;
        else if (miss && acc_rd)      rdbuf <= '0;
    end

    // Response register: port answer first, then busy, then local.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid  <= 1'b0;
            resp_rdata  <= '0;
            resp_status <= ST_OK;
        end else begin
            resp_valid  <= 1'b0;
            resp_rdata  <= '0;
            resp_status <= ST_OK;
            if (ap_done) begin
                resp_valid <= 1'b1;
                resp_rdata <= ap_done_rd ? ap_rsp_rdata : 32'h0;
            end else if (acc_valid && ap_pend) begin
                resp_valid  <= 1'b1;
                resp_status <= ST_BUSY;
            end else if (take && !acc_ap) begin
                resp_valid <= 1'b1;
                resp_rdata <= acc_rd ? local_rdata : 32'h0;
            end else if (miss) begin
                resp_valid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dpreg_front_chk.sv
`timescale 1ns/1ps
// Protocol checks for dpreg_front, attached by bind.
module dpreg_front_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       acc_valid,
    input logic       acc_ap,
    input logic       acc_rd,
    input logic       resp_valid,
    input logic [31:0] resp_rdata,
    input logic [1:0] resp_status,
    input logic       ap_req_valid,
    input logic [7:0] ap_req_off,
    input logic       ap_rsp_valid,
    input logic       pend
);
    AST_REQ_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        ap_req_valid |=> !ap_req_valid); // R5
    AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        ap_req_valid |-> ap_req_off[1:0] == 2'b00); // R5
    AST_LOCAL_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_ap && !pend) |=> (resp_valid && resp_status == 2'b00)); // R2
    AST_BUSY_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && pend && !ap_rsp_valid) |=> (resp_valid && resp_status == 2'b01)); // R9
    AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && pend) |=> !ap_req_valid); // R9
    AST_WRITE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_rd && !pend) |=> resp_rdata == 32'h0); // R10
    AST_IDLE_RSP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ap_rsp_valid && !pend && !acc_valid) |=> !resp_valid); // R11
endmodule

bind dpreg_front dpreg_front_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_valid    (acc_valid),
    .acc_ap       (acc_ap),
    .acc_rd       (acc_rd),
    .resp_valid   (resp_valid),
    .resp_rdata   (resp_rdata),
    .resp_status  (resp_status),
    .ap_req_valid (ap_req_valid),
    .ap_req_off   (ap_req_off),
    .ap_rsp_valid (ap_rsp_valid),
    .pend         (ap_pend)
);

// File: tb/dpreg_front_test.sv
`timescale 1ns/1ps
module dpreg_front_test;
    localparam int          NUM_AP = 2;
    localparam logic [31:0] ID     = 32'h0C0D_E001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_ap = 1'b0, acc_rd = 1'b0;
    logic [1:0]  acc_addr = 2'b00;
    logic [31:0] acc_wdata = 32'h0;
    logic        resp_valid;
    logic [31:0] resp_rdata;
    logic [1:0]  resp_status;
    logic        ap_req_valid;
    logic [0:0]  ap_req_sel;
    logic [7:0]  ap_req_off;
    logic        ap_req_wr;
    logic [31:0] ap_req_wdata;
    logic        ap_rsp_valid = 1'b0;
    logic [31:0] ap_rsp_rdata = 32'h0;

    int    nchk = 0, nerr = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    dpreg_front #(.NUM_AP(NUM_AP), .DP_ID(ID)) uut (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_ap(acc_ap), .acc_rd(acc_rd),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata), .resp_status(resp_status),
        .ap_req_valid(ap_req_valid), .ap_req_sel(ap_req_sel), .ap_req_off(ap_req_off),
        .ap_req_wr(ap_req_wr), .ap_req_wdata(ap_req_wdata),
        .ap_rsp_valid(ap_rsp_valid), .ap_rsp_rdata(ap_rsp_rdata)
    );

    task automatic chk(string r, string what, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
        end
    endtask

    // Behavioural reference state.
    int unsigned m_port = 0, m_pbank = 0, m_lbank = 0;
    logic [31:0] m_ctrl = 0, m_rdbuf = 0;
    bit          m_pend = 0, m_prd = 0;
    bit          e_rv = 0, e_reqv = 0, e_wr = 0;
    logic [31:0] e_rd = 0, e_wd = 0;
    int unsigned e_st = 0, e_sel = 0, e_off = 0;

    // Model one clock and compare all outputs shortly after the edge.
    always @(posedge clk) begin
        bit was_pend;
        was_pend = m_pend;
        e_rv = 0; e_rd = 0; e_st = 0; e_reqv = 0;
        if (!rst_n) begin
            m_port = 0; m_pbank = 0; m_lbank = 0; m_ctrl = 0; m_rdbuf = 0;
            m_pend = 0; m_prd = 0;
        end else if (was_pend && ap_rsp_valid) begin
            e_rv = 1;
            if (m_prd) begin e_rd = ap_rsp_rdata; m_rdbuf = ap_rsp_rdata; end
            m_pend = 0;
        end else if (acc_valid && was_pend) begin
            e_rv = 1; e_st = 1;
        end else if (acc_valid && !acc_ap) begin
            e_rv = 1;
            if (acc_rd) begin
                case (acc_addr)
                    2'd0: e_rd = ID;
                    2'd1: e_rd = (m_lbank == 0) ? m_ctrl : 0;
                    2'd2: e_rd = (m_port << 24) | (m_pbank << 4) | m_lbank;
                    default: e_rd = m_rdbuf;
                endcase
            end else if (acc_addr == 2'd2) begin
                m_port = acc_wdata[31:24]; m_pbank = acc_wdata[7:4]; m_lbank = acc_wdata[3:0];
            end else if (acc_addr == 2'd1 && m_lbank == 0) begin
                m_ctrl = acc_wdata;
            end
        end else if (acc_valid && m_port >= NUM_AP) begin
            e_rv = 1;
            if (acc_rd) m_rdbuf = 0;
        end else if (acc_valid) begin
            e_reqv = 1; e_sel = m_port; e_off = m_pbank * 16 + acc_addr * 4;
            e_wr = !acc_rd; e_wd = acc_wdata; m_pend = 1; m_prd = acc_rd;
        end
        #1;
        chk(cur_req, "resp_valid", 32'(resp_valid), 32'(e_rv));
        chk(cur_req, "resp_rdata", resp_rdata, e_rd);
        chk(cur_req, "resp_status", 32'(resp_status), e_st);
        chk(cur_req, "ap_req_valid", 32'(ap_req_valid), 32'(e_reqv));
        if (e_reqv) begin
            chk(cur_req, "ap_req_sel", 32'(ap_req_sel), e_sel);
            chk(cur_req, "ap_req_off", 32'(ap_req_off), e_off);
            chk(cur_req, "ap_req_wr", 32'(ap_req_wr), 32'(e_wr));
            chk(cur_req, "ap_req_wdata", ap_req_wdata, e_wd);
        end
    end

    // Present one access for one edge; optional literal check of resp_rdata.
    task automatic access(string r, bit ap, bit rd, logic [1:0] a, logic [31:0] d,
                          bit do_chk = 0, logic [31:0] exp = 0);
        @(negedge clk);
        cur_req = r;
        acc_valid = 1; acc_ap = ap; acc_rd = rd; acc_addr = a; acc_wdata = d;
        @(posedge clk); #1;
        if (do_chk) chk(r, "directed rdata", resp_rdata, exp);
        @(negedge clk);
        acc_valid = 0;
    endtask

    task automatic reply(int lat, logic [31:0] d);
        repeat (lat) @(negedge clk);
        ap_rsp_valid = 1; ap_rsp_rdata = d;
        @(negedge clk);
        ap_rsp_valid = 0; ap_rsp_rdata = 0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    initial begin
        #400000;
        nerr++;
        $display("FAIL watchdog all requirements actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset contents
        access("R1", 0, 1, 2'b10, 0, 1, 32'h0);
        access("R1", 0, 1, 2'b01, 0, 1, 32'h0);
        access("R1", 0, 1, 2'b11, 0, 1, 32'h0);
        // R2: identification word, write ignored
        access("R2", 0, 1, 2'b00, 0, 1, ID);
        access("R2", 0, 0, 2'b00, 32'hFFFF_FFFF);
        access("R2", 0, 1, 2'b00, 0, 1, ID);
        // R3: selection register field masking
        access("R3", 0, 0, 2'b10, 32'hFFFF_FFFF);
        access("R3", 0, 1, 2'b10, 0, 1, 32'hFF00_00FF);
        // R4: non-zero local bank reads zero, writes ignored
        access("R4", 0, 0, 2'b01, 32'h1111_2222);
        access("R4", 0, 1, 2'b01, 0, 1, 32'h0);
        access("R4", 0, 0, 2'b10, 32'h0000_0000);
        access("R4", 0, 1, 2'b01, 0, 1, 32'h0);
        access("R4", 0, 0, 2'b01, 32'h1234_5678);
        access("R4", 0, 1, 2'b01, 0, 1, 32'h1234_5678);
        // R5/R6: port 1, bank 1, address 2'b01 -> offset 0x14
        access("R3", 0, 0, 2'b10, 32'h0100_0010);
        access("R5", 1, 0, 2'b01, 32'hF000_0001);
        chk("R5", "offset literal", 32'(ap_req_off), 32'h14);
        reply(2, 32'hDEAD_0000);
        @(negedge clk);
        access("R6", 1, 1, 2'b11, 0);
        chk("R5", "offset literal", 32'(ap_req_off), 32'h1C);
        // R9: accesses while pending get BUSY and change nothing
        access("R9", 0, 1, 2'b00, 0);
        access("R9", 0, 0, 2'b10, 32'h0500_0000);
        reply(1, 32'hCAFE_0001);
        @(negedge clk);
        access("R8", 0, 1, 2'b11, 0, 1, 32'hCAFE_0001);
        access("R9", 0, 1, 2'b10, 0, 1, 32'h0100_0010);
        // R8: write to read buffer ignored
        access("R8", 0, 0, 2'b11, 32'h0);
        access("R8", 0, 1, 2'b11, 0, 1, 32'hCAFE_0001);
        // R11: answer with nothing outstanding
        cur_req = "R11";
        reply(0, 32'h5555_5555);
        repeat (2) @(negedge clk);
        // R9: access in the same cycle as the port answer is discarded
        access("R9", 1, 1, 2'b00, 0);
        @(negedge clk);
        cur_req = "R9";
        acc_valid = 1; acc_ap = 0; acc_rd = 0; acc_addr = 2'b10; acc_wdata = 32'h0700_0000;
        ap_rsp_valid = 1; ap_rsp_rdata = 32'h0BAD_F00D;
        @(negedge clk);
        acc_valid = 0; ap_rsp_valid = 0;
        access("R9", 0, 1, 2'b10, 0, 1, 32'h0100_0010);
        // R7: unimplemented port
        access("R7", 0, 0, 2'b10, 32'h0500_0020);
        access("R7", 1, 1, 2'b00, 0, 1, 32'h0);
        access("R8", 0, 1, 2'b11, 0, 1, 32'h0);
        access("R7", 1, 0, 2'b10, 32'h1357_9BDF);
        // R10: port write answer carries zero, port 0 bank 2 -> offset 0x20
        access("R3", 0, 0, 2'b10, 32'h0000_0020);
        access("R10", 1, 0, 2'b00, 32'hAAAA_5555);
        chk("R5", "offset literal", 32'(ap_req_off), 32'h20);
        reply(3, 32'hFFFF_FFFF);
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule